// File: doc/BRIEF.md
# Carry-Save Tree Unsigned Multiplier

This block multiplies two unsigned operands of equal width and returns the full double-width product in the same cycle. It has no clock and no state. Every partial-product row is the operand `a_i` gated by one bit of `b_i` and moved left by that bit's index. The rows then pass through layers of carry-save adders. Each layer takes groups of three rows and turns every group into two rows. Rows that do not fill a group of three go on to the next layer unchanged. This repeats until two rows are left. The only carry propagation in the whole datapath happens in one final lookahead addition of those two rows.

The structure is fixed once the operand width is chosen. The package works out how many rows each layer has and how many layers the width needs. Generate loops then build exactly that tree. Eight-bit operands need four carry-save layers (8, 6, 4, 3, then 2 rows). Four-bit operands need two layers.

Top module: `wallace_mult`

## Requirements
- R1: For every pair of unsigned operands, `prod_o` equals `a_i * b_i`, 2N bits wide.
- R2: When either operand is zero, `prod_o` is zero.
- R3: With both operands at their maximum value 2^N-1, `prod_o` equals 2^(2N) - 2^(N+1) + 1 (0xFE01 for N=8). No carry is lost in the upper product bits.
- R4: When one operand is 1, `prod_o` equals the other operand, zero-extended to 2N bits.
- R5: Bit 0 of `prod_o` is the AND of bit 0 of `a_i` and bit 0 of `b_i`.
- R6: When `b_i` is 2^k, `prod_o` equals `a_i` shifted left by k bits.
- R7: A 4-bit build, whose tree has only two carry-save layers, also meets R1 for all operand pairs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | N | Multiplicand, unsigned |
| b_i | input | N | Multiplier, unsigned; bit i enables partial-product row i |
| prod_o | output | 2N | Unsigned product |

## Verification
The bench builds the block twice. One build uses the default width of 8, which gives a four-layer tree and a four-group lookahead adder. The other uses width 4, which gives the shortest tree that still has more than one layer. Both widths are small enough to sweep every operand pair, so every carry pattern through every full adder and every group carry in the final adder is exercised. Directed checks on top of the sweep cover zero, one, powers of two and the all-ones corner.

// File: rtl/wt_pkg.sv
package wt_pkg;

    // rows left after one 3:2 layer acting on r rows
    function automatic int rows_after(input int r);
        return 2 * (r / 3) + (r % 3);
    endfunction

    // rows entering layer l of a tree that starts with n rows
    function automatic int rows_at(input int n, input int l);
        int r;
        r = n;
        for (int i = 0; i < l; i++) r = rows_after(r);
        return r;
    endfunction

    // number of 3:2 layers needed to reach two rows
    function automatic int layer_count(input int n);
        int r;
        int c;
        r = n;
        c = 0;
        while (r > 2) begin
            r = rows_after(r);
            c++;
        end
        return c;
    endfunction

endpackage

// File: rtl/wt_ppgen.sv
module wt_ppgen #(
    parameter int N = 8
) (
    input  logic [N-1:0]   a_i,
    input  logic [N-1:0]   b_i,
    output logic [2*N-1:0] rows_o [N]
);
    localparam int W2 = 2 * N;

    for (genvar i = 0; i < N; i++) begin : g_row
        logic [W2-1:0] gated;
        assign gated     = {{N{1'b0}}, a_i & {N{b_i[i]}}};
        assign rows_o[i] = gated << i;
    end
endmodule

// File: rtl/wt_csa.sv
module wt_csa #(
    parameter int W = 16
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    input  logic [W-1:0] z_i,
    output logic [W-1:0] sum_o,
    output logic [W-1:0] cry_o
);
    // independent full adders; each carry lands one position higher
    assign sum_o    = x_i ^ y_i ^ z_i;
    assign cry_o[0] = 1'b0;
    for (genvar i = 1; i < W; i++) begin : g_fa
        assign cry_o[i] = (x_i[i-1] & y_i[i-1]) | (x_i[i-1] & z_i[i-1]) |
                          (y_i[i-1] & z_i[i-1]);
    end
endmodule

// File: rtl/wt_cla.sv
module wt_cla #(
    parameter int W   = 16,
    parameter int GRP = 4
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    output logic [W-1:0] sum_o
);
    localparam int NGRP = (W + GRP - 1) / GRP;

    logic [W-1:0] prp;
    logic [W-2:0] gen;
    logic [W-1:0] cin;
    logic [NGRP-1:0] gcar;

    assign prp = x_i ^ y_i;
    assign gen = x_i[W-2:0] & y_i[W-2:0];

    always_comb begin
        // carry into each group from group generate/propagate terms
        gcar[0] = 1'b0;
        for (int k = 1; k < NGRP; k++) begin
            logic gg;
            logic gp;
            gg = 1'b0;
            gp = 1'b1;
            for (int j = (k - 1) * GRP; j < k * GRP; j++) begin
                gg = gen[j] | (prp[j] & gg);
                gp = gp & prp[j];
            end
            gcar[k] = gg | (gp & gcar[k-1]);
        end
        // carry into each bit as a sum of products within its group
        for (int i = 0; i < W; i++) begin
            int   base;
            logic acc;
            logic term;
            base = (i / GRP) * GRP;
            term = gcar[i / GRP];
            for (int m = base; m < i; m++) term = term & prp[m];
            acc = term;
            for (int m = base; m < i; m++) begin
                term = gen[m];
                for (int q = m + 1; q < i; q++) term = term & prp[q];
                acc = acc | term;
            end
            cin[i] = acc;
        end
    end

    assign sum_o = prp ^ cin;
endmodule

// File: rtl/wallace_mult.sv
module wallace_mult
    import wt_pkg::*;
#(
    parameter int N = 8
) (
    input  logic [N-1:0]   a_i,
    input  logic [N-1:0]   b_i,
    output logic [2*N-1:0] prod_o
);
    localparam int W2     = 2 * N;
    localparam int LAYERS = layer_count(N);

    logic [W2-1:0] pp [N];
    logic [W2-1:0] fin_x;
    logic [W2-1:0] fin_y;

    wt_ppgen #(.N(N)) u_ppgen (
        .a_i    (a_i),
        .b_i    (b_i),
        .rows_o (pp)
    );

    for (genvar l = 0; l < LAYERS; l++) begin : g_lay
        localparam int RIN  = rows_at(N, l);
        localparam int ROUT = rows_at(N, l + 1);
        localparam int NG   = RIN / 3;
        logic [W2-1:0] din  [RIN];
        logic [W2-1:0] dout [ROUT];

        if (l == 0) begin : g_src_pp
            assign din = pp;
        end else begin : g_src_prev
            assign din = g_lay[l-1].dout;
        end

        for (genvar g = 0; g < NG; g++) begin : g_grp
            wt_csa #(.W(W2)) u_csa (
                .x_i   (din[3*g]),
                .y_i   (din[3*g+1]),
                .z_i   (din[3*g+2]),
                .sum_o (dout[2*g]),
                .cry_o (dout[2*g+1])
            );
        end
        for (genvar j = 0; j < RIN - 3 * NG; j++) begin : g_pass
            assign dout[2*NG+j] = din[3*NG+j];
        end
    end

    if (LAYERS == 0) begin : g_direct
        assign fin_x = pp[0];
        assign fin_y = pp[N-1];
    end else begin : g_tree
        assign fin_x = g_lay[LAYERS-1].dout[0];
        assign fin_y = g_lay[LAYERS-1].dout[1];
    end

    wt_cla #(.W(W2), .GRP(4)) u_cla (
        .x_i   (fin_x),
        .y_i   (fin_y),
        .sum_o (prod_o)
    );
endmodule

// File: rtl/wallace_mult_chk.sv
module wallace_mult_chk #(
    parameter int N = 8
) (
    input logic [N-1:0]   a_i,
    input logic [N-1:0]   b_i,
    input logic [2*N-1:0] prod_o
);
    logic [2*N-1:0] ref_p;
    assign ref_p = {{N{1'b0}}, a_i} * {{N{1'b0}}, b_i};

    always_comb begin
        assert_product_R1: assert (prod_o == ref_p)
            else $error("product mismatch");
        if (a_i == '0 || b_i == '0)
            assert_zero_R2: assert (prod_o == '0)
                else $error("zero operand gave nonzero");
        if (b_i == N'(1))
            assert_unit_R4: assert (prod_o == {{N{1'b0}}, a_i})
                else $error("unit multiplier mismatch");
        assert_lsb_R5: assert (prod_o[0] == (a_i[0] & b_i[0]))
            else $error("lsb mismatch");
    end
endmodule

bind wallace_mult wallace_mult_chk #(.N(N)) u_chk (
    .a_i    (a_i),
    .b_i    (b_i),
    .prod_o (prod_o)
);

// File: tb/wallace_mult_tb_top.sv
`timescale 1ns/1ps
module wallace_mult_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    logic [7:0]  a8, b8;
    logic [15:0] p8;
    logic [3:0]  a4, b4;
    logic [7:0]  p4;

    wallace_mult #(.N(8)) dut_i  (.a_i(a8), .b_i(b8), .prod_o(p8));
    wallace_mult #(.N(4)) dut4_i (.a_i(a4), .b_i(b4), .prod_o(p4));

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic drive8(input int a, input int b);
        @(posedge clk);
        a8 = 8'(a);
        b8 = 8'(b);
        @(negedge clk);
    endtask

    initial begin
        a8 = '0; b8 = '0; a4 = '0; b4 = '0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R2 idle zero", int'(p8), 0);

        // R2: zero operand on either side
        drive8(8'hA5, 0);   chk("R2 b zero", int'(p8), 0);
        drive8(0, 8'hFF);   chk("R2 a zero", int'(p8), 0);
        // R3: all-ones corner
        drive8(255, 255);   chk("R3 max", int'(p8), 16'hFE01);
        // R4: unit operand
        drive8(8'h9C, 1);   chk("R4 b one", int'(p8), 8'h9C);
        drive8(1, 8'hE7);   chk("R4 a one", int'(p8), 8'hE7);
        // R5: low bit
        drive8(3, 5);       chk("R5 lsb set", int'(p8[0]), 1);
        drive8(3, 6);       chk("R5 lsb clear", int'(p8[0]), 0);
        // R6: powers of two
        for (int k = 0; k < 8; k++) begin
            drive8(8'hB7, 1 << k);
            chk("R6 shift", int'(p8), 8'hB7 << k);
        end

        // R1: exhaustive 8-bit sweep
        for (int a = 0; a < 256; a++) begin
            for (int b = 0; b < 256; b++) begin
                drive8(a, b);
                chk("R1 sweep8", int'(p8), a * b);
            end
        end

        // R7: exhaustive 4-bit sweep on the two-layer build
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                @(posedge clk);
                a4 = 4'(a);
                b4 = 4'(b);
                @(negedge clk);
                chk("R7 sweep4", int'(p4), a * b);
            end
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule